// File: doc/BRIEF.md
# Handshake Dataflow Join Adder

This block is one processing stage in a dataflow network. It is modelled synchronously: each self-timed channel becomes a valid/ready pair. Two operand channels each feed a holding register of their own, and each channel completes its handshake without regard to the other.

Once both registers hold a value, the stage forms their full-width sum. It offers that sum at the same moment to every consumer attached to the result channel. The sum stays on offer until each consumer has taken it once. Only then does the stage empty both operand registers and begin its next round.

Because each operand has its own handshake, a producer that feeds both this stage and an upstream partner cannot lock the network by waiting on a combined input acknowledgement.

Top module: `hsj_join_adder`

## Requirements
- R1: `sumData` equals the unsigned sum of the two captured operands. It is one bit wider than an operand, so the carry out is kept (0xFFFF + 0xFFFF = 0x1FFFE).
- R2: `aReady` is high exactly when the A holding register is empty, and `bReady` likewise for B. Neither depends on the valid or the presence of the other operand.
- R3: An operand transfer happens on a clock edge where that channel's valid and ready are both high. After it, that channel's ready stays low until the result is retired.
- R4: No result is offered before both operands are held. The result is offered to all consumers together, on the edge after the later of the two captures.
- R5: While a consumer's `sumValid` bit is high and its `sumReady` bit is low, that bit stays high and `sumData` holds its value.
- R6: A consumer that has taken the current result sees its `sumValid` bit go low on the next cycle. It is not offered that result again while the other consumers are still pending.
- R7: The result retires on the edge where the last pending consumer accepts it. Both operand registers are empty after that edge, so both readys are high in the following cycle.
- R8: While the synchronous active-high reset is applied and after it is released, both readys are high, no `sumValid` bit is set, and `sumData` reads zero.
- R9: Every consumer receives every result exactly once, in the order the operand pairs were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aValid | input | 1 | Operand A offered |
| aData | input | 16 | Operand A value |
| aReady | output | 1 | Operand A register empty |
| bValid | input | 1 | Operand B offered |
| bData | input | 16 | Operand B value |
| bReady | output | 1 | Operand B register empty |
| sumValid | output | NUM_SINKS | Per-consumer result offer |
| sumData | output | 17 | Result value |
| sumReady | input | NUM_SINKS | Per-consumer take |

## Verification
The hardest situation to produce is a split broadcast. In it, one consumer has already taken the result, another is still stalled, and fresh operands are waiting upstream. A consumer that is offered the result a second time, or a result that retires early, shows up only in this state.

The stimulus builds this state on purpose: one consumer is held not-ready while the other accepts, and both operand producers keep offering. A phase that feeds only one operand shows that its handshake completes without the other. Random valid and ready patterns then mix early and late consumers across many rounds.

// File: rtl/hsj_pkg.sv
package hsj_pkg;
  // strobes issued by control to the datapath each cycle
  typedef struct packed {
    logic capA;    // load operand A register
    logic capB;    // load operand B register
    logic launch;  // register the sum and start the broadcast
    logic retire;  // last consumer took the result
  } ctlStrobe_t;
endpackage

// File: rtl/hsj_datapath.sv
module hsj_datapath
  import hsj_pkg::*;
#(
  parameter int OPND_W = 16,
  localparam int SUM_W = OPND_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        strobe,
  input  logic [OPND_W-1:0] aData,
  input  logic [OPND_W-1:0] bData,
  output logic [SUM_W-1:0]  sumData
);
  logic [OPND_W-1:0] aReg, bReg;
  logic [SUM_W-1:0]  sumReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      aReg   <= '0;
      bReg   <= '0;
      sumReg <= '0;
    end else begin
      if (strobe.capA)   aReg   <= aData;
      if (strobe.capB)   bReg   <= bData;
      if (strobe.launch) sumReg <= {1'b0, aReg} + {1'b0, bReg};
    end
  end

  assign sumData = sumReg;
endmodule

// File: rtl/hsj_control.sv
module hsj_control
  import hsj_pkg::*;
#(
  parameter int NUM_SINKS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 aValid,
  input  logic                 bValid,
  input  logic [NUM_SINKS-1:0] sumReady,
  output logic                 aReady,
  output logic                 bReady,
  output logic [NUM_SINKS-1:0] sumValid,
  output ctlStrobe_t           strobe
);
  logic                 aFull, bFull;
  logic [NUM_SINKS-1:0] pend;
  logic [NUM_SINKS-1:0] pendLeft;

  assign pendLeft = pend & ~sumReady;

  always_comb begin
    strobe.capA   = aValid & ~aFull;
    strobe.capB   = bValid & ~bFull;
    strobe.launch = aFull & bFull & ~(|pend);
    strobe.retire = (|pend) & ~(|pendLeft);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aFull <= 1'b0;
      bFull <= 1'b0;
      pend  <= '0;
    end else begin
      if (strobe.retire)    aFull <= 1'b0;
      else if (strobe.capA) aFull <= 1'b1;
      if (strobe.retire)    bFull <= 1'b0;
      else if (strobe.capB) bFull <= 1'b1;
      if (strobe.launch) pend <= '1;
      else               pend <= pendLeft;
    end
  end

  assign aReady   = ~aFull;
  assign bReady   = ~bFull;
  assign sumValid = pend;
endmodule

// File: rtl/hsj_join_adder.sv
module hsj_join_adder
  import hsj_pkg::*;
#(
  parameter int OPND_W    = 16,
  parameter int NUM_SINKS = 2,
  localparam int SUM_W = OPND_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 aValid,
  input  logic [OPND_W-1:0]    aData,
  output logic                 aReady,
  input  logic                 bValid,
  input  logic [OPND_W-1:0]    bData,
  output logic                 bReady,
  output logic [NUM_SINKS-1:0] sumValid,
  output logic [SUM_W-1:0]     sumData,
  input  logic [NUM_SINKS-1:0] sumReady
);
  ctlStrobe_t strobe;

  hsj_control #(.NUM_SINKS(NUM_SINKS)) ctl_i (
    .clk(clk), .rst(rst), .aValid(aValid), .bValid(bValid),
    .sumReady(sumReady), .aReady(aReady), .bReady(bReady),
    .sumValid(sumValid), .strobe(strobe)
  );

  hsj_datapath #(.OPND_W(OPND_W)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe),
    .aData(aData), .bData(bData), .sumData(sumData)
  );
endmodule

// File: rtl/hsj_join_adder_chk.sv
module hsj_join_adder_chk #(
  parameter int OPND_W    = 16,
  parameter int NUM_SINKS = 2,
  localparam int SUM_W = OPND_W + 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 aValid,
  input logic                 aReady,
  input logic                 bValid,
  input logic                 bReady,
  input logic [NUM_SINKS-1:0] sumValid,
  input logic [SUM_W-1:0]     sumData,
  input logic [NUM_SINKS-1:0] sumReady
);
  AST_A_FULL_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    aValid && aReady |=> !aReady); // R3
  AST_B_FULL_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    bValid && bReady |=> !bReady); // R3
  AST_OFFER_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
    (|sumValid) |-> (!aReady && !bReady)); // R4
  AST_OFFER_ALL_AT_ONCE: assert property (@(posedge clk) disable iff (rst)
    $rose(|sumValid) |-> (&sumValid)); // R4

  for (genvar i = 0; i < NUM_SINKS; i++) begin : g_sink
    AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (rst)
      sumValid[i] && !sumReady[i] |=> sumValid[i] && $stable(sumData)); // R5
    AST_NO_REOFFER: assert property (@(posedge clk) disable iff (rst)
      sumValid[i] && sumReady[i] |=> !sumValid[i]); // R6
  end
endmodule

bind hsj_join_adder hsj_join_adder_chk #(.OPND_W(OPND_W), .NUM_SINKS(NUM_SINKS)) chk_i (
  .clk(clk), .rst(rst), .aValid(aValid), .aReady(aReady), .bValid(bValid),
  .bReady(bReady), .sumValid(sumValid), .sumData(sumData), .sumReady(sumReady)
);

// File: tb/hsj_join_adder_tb_top.sv
module hsj_join_adder_tb_top;
  localparam int W = 16;
  localparam int NS = 2;
  localparam int NTX = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic aValid = 1'b0, bValid = 1'b0;
  logic [W-1:0] aData = '0, bData = '0;
  logic aReady, bReady;
  logic [NS-1:0] sumValid;
  logic [W:0] sumData;
  logic [NS-1:0] sumReady = '0;

  int checks = 0, errors = 0;
  logic [W-1:0] aVals [NTX];
  logic [W-1:0] bVals [NTX];
  int sentA = 0, sentB = 0;
  int rcv [NS];
  logic fireA = 0, fireB = 0;
  logic enA = 0, enB = 0, rndIn = 0;
  int rdyMode = 0; // 0 none, 1 all, 2 only sink0, 3 random

  always #2.5 clk = ~clk;

  hsj_join_adder #(.OPND_W(W), .NUM_SINKS(NS)) dut_i (
    .clk(clk), .rst(rst), .aValid(aValid), .aData(aData), .aReady(aReady),
    .bValid(bValid), .bData(bData), .bReady(bReady),
    .sumValid(sumValid), .sumData(sumData), .sumReady(sumReady)
  );

  function automatic logic [W:0] expSum(int k);
    return {1'b0, aVals[k]} + {1'b0, bVals[k]};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: handshakes seen here complete at the next rising edge
  initial begin
    for (int i = 0; i < NS; i++) rcv[i] = 0;
    forever begin
      @(negedge clk);
      fireA = aValid && aReady && !rst;
      fireB = bValid && bReady && !rst;
      for (int i = 0; i < NS; i++) begin
        if (!rst && sumValid[i] && sumReady[i]) begin
          if (rcv[i] < NTX)
            check(sumData == expSum(rcv[i]), "R1/R9 result value", 32'(sumData), 32'(expSum(rcv[i])));
          else
            check(1'b0, "R9 extra result", 32'(rcv[i]), NTX);
          rcv[i]++;
        end
      end
      if (!rst && (|sumValid))
        check(!aReady && !bReady, "R7 inputs held during broadcast", {aReady, bReady}, 0);
    end
  end

  // operand drivers
  initial begin
    forever begin
      @(posedge clk); #1;
      if (fireA) sentA++;
      aValid = enA && (sentA < NTX) && (!rndIn || ($urandom % 3 != 0));
      aData  = (sentA < NTX) ? aVals[sentA] : '0;
    end
  end
  initial begin
    forever begin
      @(posedge clk); #1;
      if (fireB) sentB++;
      bValid = enB && (sentB < NTX) && (!rndIn || ($urandom % 3 != 0));
      bData  = (sentB < NTX) ? bVals[sentB] : '0;
    end
  end
  // consumer ready driver
  initial begin
    forever begin
      @(posedge clk); #1;
      case (rdyMode)
        1: sumReady = '1;
        2: sumReady = 2'b01;
        3: sumReady = NS'($urandom);
        default: sumReady = '0;
      endcase
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < NTX; k++) begin
      aVals[k] = W'($urandom);
      bVals[k] = W'($urandom);
    end
    aVals[0] = 16'hFFFF; bVals[0] = 16'hFFFF; // carry corner
    aVals[1] = 16'h0000; bVals[1] = 16'h0001;

    // R8: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(aReady && bReady, "R8 readys in reset", {aReady, bReady}, 3);
    check(sumValid == 0, "R8 no offer in reset", sumValid, 0);
    @(posedge clk); #1 rst = 0;
    @(negedge clk);
    check(aReady && bReady && sumValid == 0 && sumData == 0, "R8 after release",
          {aReady, bReady, sumValid, 15'(sumData)}, {4'b1100, 15'd0});

    // R2/R4: only operand A offered
    enA = 1;
    repeat (6) @(negedge clk);
    check(!aReady, "R2/R3 A taken alone", aReady, 0);
    check(bReady, "R2 B ready independent", bReady, 1);
    check(sumValid == 0, "R4 no offer with one operand", sumValid, 0);
    enB = 1;
    // B driven after edge k+1, captured at k+2, offered after k+3
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(sumValid == 0, "R4 not offered on capture edge", sumValid, 0);
    @(negedge clk);
    check(sumValid == 2'b11, "R4 offered to all", sumValid, 3);
    check(sumData == 17'h1FFFE, "R1 carry kept", sumData, 32'h1FFFE);
    enA = 0; enB = 0;
    repeat (3) @(negedge clk);
    check(sumValid == 2'b11, "R5 offer held", sumValid, 3);
    check(sumData == 17'h1FFFE, "R5 data stable", sumData, 32'h1FFFE);
    rdyMode = 1;
    @(negedge clk); // ready high now, taken at next edge
    @(negedge clk);
    check(sumValid == 0, "R7 retired", sumValid, 0);
    check(aReady && bReady, "R7 readys back", {aReady, bReady}, 3);

    // R6: split broadcast, sink1 stalled while inputs wait upstream
    rdyMode = 2; enA = 1; enB = 1;
    repeat (10) @(negedge clk);
    check(sumValid == 2'b10, "R6 only stalled sink pending", sumValid, 2);
    check(rcv[0] == 2 && rcv[1] == 1, "R6 sink0 got result once", {rcv[0][15:0], rcv[1][15:0]}, {16'd2, 16'd1});
    check(!aReady && !bReady, "R7 not retired while pending", {aReady, bReady}, 0);

    // random phase
    rdyMode = 3; rndIn = 1;
    while (rcv[0] < NTX || rcv[1] < NTX) @(negedge clk);
    repeat (10) @(negedge clk);
    for (int i = 0; i < NS; i++)
      check(rcv[i] == NTX, "R9 result count", rcv[i], NTX);
    finishRun();
  end
endmodule